// File: doc/BRIEF.md
# Cache Event Performance Counters

This block holds a small bank of performance counters that watch a cache controller. Every clock the controller presents a vector of one-cycle event strobes. Each counter is set to one event by a numeric code and adds one in every cycle where that event is active. Code 0 is an internal always-true event, so a counter set to it counts clock cycles.

Software reaches the bank through two ports. The configuration port writes one counter's event code and its clear-on-read flag. A configuration write never changes the count. The read port takes a counter index and returns that counter's value one cycle later. If the counter has clear-on-read set, the read also resets the counter to zero.

Top module: `cache_perf_counters`

## Requirements
- R1: After reset every count is zero. Every event code resets to all-ones, which is an out-of-range code, so an idle counter stays at zero. Every clear-on-read flag resets to 0.
- R2: A read is requested by rd_en_i high at a clock edge, with the counter chosen by rd_idx_i. After that edge rd_data_o holds the counter's value and rd_valid_o is high. rd_valid_o is low after any edge where rd_en_i was low.
- R3: A counter with event code 0 increments on every clock edge, whatever the state of evt_i.
- R4: A counter with event code k, for k from 1 to 53, increments at each edge where evt_i[k-1] is high. Counters that select the same event count the same edges, each on its own.
- R5: A counter with an event code from 54 to 63 never increments.
- R6: A read of a counter whose clear-on-read flag is set returns the count and resets the count. A read with the flag clear leaves the count unchanged.
- R7: If a clearing read and the counter's selected event fall on the same edge, the counter is loaded with 1. If the event is not active, it is loaded with 0. The read returns the value from before the clear.
- R8: A configuration write leaves the count unchanged. The new code and flag take effect from the next edge onward.
- R9: A counter of width CNT_W wraps from all-ones to zero and does not saturate. The default width is 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 53 | Event strobes; bit k-1 is the strobe for event code k |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_idx_i | input | 2 | Counter to configure |
| cfg_sel_i | input | 6 | Event code to write |
| cfg_clr_rd_i | input | 1 | Clear-on-read flag to write |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 2 | Counter to read |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | CNT_W (64) | Count captured by the last read |

## Verification
Three counters are given different codes: a miss event, a hit event and an out-of-range code. They are then driven with a burst pattern in which the two strobes are sometimes high together, sometimes alone, and sometimes high along with every other strobe. This pattern separates correct per-code selection from neighbour bits leaking in and from out-of-range codes counting. Pairs of back-to-back reads tell clear-on-read apart from plain reads. A clearing read taken while the event is held shows the load-one rule on that edge. A cycle-count window of 260 edges, read through an 8-bit copy of the block, exposes missing wrap-around. Reconfiguring a counter that already holds a count shows that its value is kept.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int NUM_CNT = 4;
  localparam int NUM_EVT = 54;
  localparam int SEL_W   = $clog2(NUM_EVT);
  localparam int IDX_W   = $clog2(NUM_CNT);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             clr_rd;
  } cnt_cfg_t;
endpackage

// File: rtl/perf_evt_mux.sv
module perf_evt_mux
  import perf_cnt_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_vec_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               hit_o
);
  // codes at or above NUM_EVT match no index and yield 0
  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (sel_i == SEL_W'(k)) hit_o = evt_vec_i[k];
    end
  end
endmodule

// File: rtl/perf_cnt_slice.sv
module perf_cnt_slice
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_vec_i,
  input  logic               cfg_we_i,
  input  cnt_cfg_t           cfg_i,
  input  logic               rd_i,
  output logic [CNT_W-1:0]   cnt_o
);
  cnt_cfg_t         cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;
  logic             clr;

  perf_evt_mux u_mux (
    .evt_vec_i (evt_vec_i),
    .sel_i     (cfg_q.sel),
    .hit_o     (hit)
  );

  assign clr = rd_i & cfg_q.clr_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{sel: '1, clr_rd: 1'b0};
    end else if (cfg_we_i) begin
      cfg_q <= cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (clr) cnt_q <= CNT_W'(hit);
    else if (hit) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sel == '0 && !rd_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  assert_bad_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sel >= SEL_W'(NUM_EVT) && !rd_i) |=> $stable(cnt_q));

  assert_clr_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && cfg_q.clr_rd) |=> cnt_q <= CNT_W'(1));

  assert_cfg_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !hit && !rd_i) |=> $stable(cnt_q));

  assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&cnt_q) && hit && !rd_i) |=> cnt_q == '0);
endmodule

// File: rtl/perf_rd_port.sv
module perf_rd_port
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rd_en_i,
  input  logic [IDX_W-1:0]              rd_idx_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  output logic [NUM_CNT-1:0]            rd_sel_o,
  output logic                          rd_valid_o,
  output logic [CNT_W-1:0]              rd_data_o
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_sel
    assign rd_sel_o[i] = rd_en_i && (rd_idx_i == IDX_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= cnt_i[rd_idx_i];
    end
  end

  assert_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  assert_rd_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel_o));
endmodule

// File: rtl/cache_perf_counters.sv
module cache_perf_counters
  import perf_cnt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-2:0] evt_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [SEL_W-1:0]   cfg_sel_i,
  input  logic               cfg_clr_rd_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [CNT_W-1:0]   rd_data_o
);
  logic [NUM_EVT-1:0]            evt_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            rd_sel;
  cnt_cfg_t                      cfg_wr;

  // code 0 is the always-active cycle event
  assign evt_vec = {evt_i, 1'b1};
  assign cfg_wr  = '{sel: cfg_sel_i, clr_rd: cfg_clr_rd_i};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    perf_cnt_slice #(.CNT_W(CNT_W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_vec_i (evt_vec),
      .cfg_we_i  (cfg_we_i && (cfg_idx_i == IDX_W'(i))),
      .cfg_i     (cfg_wr),
      .rd_i      (rd_sel[i]),
      .cnt_o     (cnt[i])
    );
  end

  perf_rd_port #(.CNT_W(CNT_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .cnt_i      (cnt),
    .rd_sel_o   (rd_sel),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: tb/cache_perf_counters_tb.sv
`timescale 1ns/1ps
module cache_perf_counters_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [52:0] evt = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [5:0]  cfg_sel = '0;
  logic        cfg_clr = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic        rd_valid, rd_valid_n;
  logic [63:0] rd_data;
  logic [7:0]  rd_data_n;
  int n_chk = 0, n_fail = 0;
  logic [63:0] got;
  logic [7:0]  got_n;

  always #4 clk = ~clk;

  cache_perf_counters u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(cfg_we),
    .cfg_idx_i(cfg_idx), .cfg_sel_i(cfg_sel), .cfg_clr_rd_i(cfg_clr),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data));

  cache_perf_counters #(.CNT_W(8)) u_dut_nar (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .cfg_we_i(cfg_we),
    .cfg_idx_i(cfg_idx), .cfg_sel_i(cfg_sel), .cfg_clr_rd_i(cfg_clr),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_valid_o(rd_valid_n),
    .rd_data_o(rd_data_n));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic cfg(input int idx, input int sel, input logic clr);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_sel = 6'(sel); cfg_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int idx);
    rd_en = 1'b1; rd_idx = 2'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data; got_n = rd_data_n;
    chk("R2 valid", 64'(rd_valid), 64'd1);
  endtask

  task automatic pulse(input logic [52:0] v, input int n);
    evt = v;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      rd(i);
      chk("R1 reset count", got, 64'd0);
    end
    @(negedge clk);
    chk("R2 idle valid", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_select;
    cfg(1, 6, 1'b0);
    cfg(2, 5, 1'b1);
    cfg(3, 60, 1'b0);
    // code6 -> bit5, code5 -> bit4
    pulse(53'h30, 2);
    pulse(53'h20, 1);
    pulse('1, 3);
    rd(1); chk("R4 hit count", got, 64'd6);
    rd(1); chk("R6 plain read keeps", got, 64'd6);
    rd(2); chk("R4 miss count", got, 64'd5);
    rd(2); chk("R6 cleared by read", got, 64'd0);
    rd(3); chk("R5 bad code idle", got, 64'd0);
  endtask

  task automatic t_reconfig;
    cfg(1, 3, 1'b1);
    rd(1); chk("R8 count kept on reconfig", got, 64'd6);
    pulse(53'h4, 2);
    pulse(53'h20, 1);
    rd(1); chk("R8 new code active", got, 64'd2);
  endtask

  task automatic t_coincide;
    evt = 53'h10;
    @(negedge clk);
    rd(2); chk("R7 read returns pre-clear", got, 64'd1);
    evt = '0;
    rd(2); chk("R7 loaded with one", got, 64'd1);
    rd(2); chk("R7 then cleared", got, 64'd0);
  endtask

  task automatic t_cycles;
    cfg(0, 0, 1'b1);
    evt = '0;
    rd(0);
    repeat (4) @(negedge clk);
    rd(0); chk("R3 cycle count", got, 64'd5);
    repeat (259) @(negedge clk);
    rd(0);
    chk("R3 long window", got, 64'd260);
    chk("R9 narrow wrap", 64'(got_n), 64'd4);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_select;
        t_reconfig;
        t_coincide;
        t_cycles;
      end
      begin
        repeat (5000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule